// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block merges the interrupt requests of a UART's receive and transmit paths into a single interrupt line and an identification value for the CPU to read. Four sources are considered. Three are level requests that the surrounding logic holds for as long as the condition lasts: receiver line status, receive data available (trigger level reached) and character timeout. The fourth is transmitter-empty, which arrives as a one-cycle event and is latched inside the block.

Each source is gated by an enable bit. Receive data available and character timeout share one enable. The highest-ranked enabled pending source sets the reported code. Line status ranks first, then the receive level, then transmitter-empty. Within the receive level, receive data available is reported ahead of timeout. The full identification value is `{src_o, no_pend_o}`. That gives 06h for line status, 04h for receive data, 0Ch for timeout, 02h for transmitter-empty and 01h when nothing is pending.

The latched transmitter-empty request is cleared in two ways: by a write to the transmit holding register, or by a read of the identification register that returned 02h. All outputs are registered.

Top module: `uart_irq_id`

## Requirements
- R1: After reset `no_pend_o` is 1, `src_o` is 3'b000 and `irq_o` is 0.
- R2: An enabled line-status request reports `src_o` = 3'b011 (ID 06h), whatever else is pending.
- R3: An enabled receive-data request reports `src_o` = 3'b010 (ID 04h) when no enabled line-status request is present.
- R4: An enabled character-timeout request reports `src_o` = 3'b110 (ID 0Ch) when neither line status nor receive data is active and enabled, and it outranks transmitter-empty.
- R5: When receive data and timeout are both active and enabled, receive data (3'b010) is reported.
- R6: A one-cycle `tx_set_i` pulse latches a transmitter-empty request that reports `src_o` = 3'b001 (ID 02h) when enabled and nothing higher is pending.
- R7: A `thr_wr_i` pulse clears the latched transmitter-empty request.
- R8: An `id_rd_i` pulse clears the latched transmitter-empty request only if the registered code being read is 3'b001 with `no_pend_o` = 0; otherwise the request stays latched.
- R9: A source whose enable is 0 neither drives `irq_o` nor affects `src_o`, and a latched transmitter-empty request survives while disabled and is reported once enabled.
- R10: `irq_o` is 1 exactly when some enabled source is pending, and `no_pend_o` is its inverse; with nothing pending `src_o` is 3'b000 (ID 01h).
- R11: Outputs are registered: a level-input change is visible after the next rising clock edge and not before.
- R12: If `tx_set_i` coincides with `thr_wr_i` or a qualifying `id_rd_i`, the new request stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_req_i | input | 1 | Receiver line-status request (level) |
| rda_req_i | input | 1 | Receive data available request (level) |
| to_req_i | input | 1 | Character-timeout request (level) |
| tx_set_i | input | 1 | Transmitter-empty event (one-cycle pulse) |
| ls_en_i | input | 1 | Line-status enable |
| rx_en_i | input | 1 | Enable for receive data and timeout |
| tx_en_i | input | 1 | Transmitter-empty enable |
| id_rd_i | input | 1 | CPU read strobe of the identification register |
| thr_wr_i | input | 1 | CPU write strobe of the transmit holding register |
| no_pend_o | output | 1 | Identification bit 0: 1 when nothing is pending |
| src_o | output | 3 | Identification bits 3:1, source code |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check the following relations on every cycle:
- the agreement between `irq_o`, `no_pend_o` and the idle code;
- line status winning over everything one cycle after it is sampled;
- receive data winning over timeout;
- a disabled line-status request never being reported;
- a holding-register write removing transmitter-empty from the report two cycles later.

Only the bench's scenarios show the latched behaviour over longer sequences:
- a read that returns a different code leaves the transmitter-empty request latched;
- a latched request survives while disabled;
- a set coincident with a clear keeps the request;
- the one-cycle output latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W  = 3;
  localparam int N_SRC  = 4;
  // source index order is the priority order, index 0 highest
  localparam int IDX_LS  = 0;
  localparam int IDX_RDA = 1;
  localparam int IDX_TO  = 2;
  localparam int IDX_TX  = 3;

  localparam logic [SRC_W-1:0] CODE_NONE = 3'b000;
  localparam logic [SRC_W-1:0] CODE_LS   = 3'b011;
  localparam logic [SRC_W-1:0] CODE_RDA  = 3'b010;
  localparam logic [SRC_W-1:0] CODE_TO   = 3'b110;
  localparam logic [SRC_W-1:0] CODE_TX   = 3'b001;

  function automatic logic [SRC_W-1:0] code_of(input int idx);
    case (idx)
      IDX_LS:  code_of = CODE_LS;
      IDX_RDA: code_of = CODE_RDA;
      IDX_TO:  code_of = CODE_TO;
      IDX_TX:  code_of = CODE_TX;
      default: code_of = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_tx_latch.sv
module uart_irq_tx_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic rd_i,
  input  logic reported_i,
  output logic pend_o
);
  logic clr;
  assign clr = wr_clr_i | (rd_i & reported_i);

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int NUM = N_SRC
) (
  input  logic [NUM-1:0]   req_i,
  output logic             any_o,
  output logic [SRC_W-1:0] code_o
);
  always_comb begin
    code_o = CODE_NONE;
    // walk from lowest to highest rank so the highest active one remains
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = code_of(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ls_req_i,
  input  logic             rda_req_i,
  input  logic             to_req_i,
  input  logic             tx_set_i,
  input  logic             ls_en_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             id_rd_i,
  input  logic             thr_wr_i,
  output logic             no_pend_o,
  output logic [SRC_W-1:0] src_o,
  output logic             irq_o
);
  logic             tx_pend;
  logic             tx_reported;
  logic [N_SRC-1:0] masked;
  logic             any_req;
  logic [SRC_W-1:0] code_nxt;

  assign tx_reported = (src_o == CODE_TX) && !no_pend_o;

  uart_irq_tx_latch u_tx (
    .clk        (clk),
    .rst        (rst),
    .set_i      (tx_set_i),
    .wr_clr_i   (thr_wr_i),
    .rd_i       (id_rd_i),
    .reported_i (tx_reported),
    .pend_o     (tx_pend)
  );

  always_comb begin
    masked          = '0;
    masked[IDX_LS]  = ls_req_i  & ls_en_i;
    masked[IDX_RDA] = rda_req_i & rx_en_i;
    masked[IDX_TO]  = to_req_i  & rx_en_i;
    masked[IDX_TX]  = tx_pend   & tx_en_i;
  end

  uart_irq_prio_enc #(.NUM(N_SRC)) u_enc (
    .req_i  (masked),
    .any_o  (any_req),
    .code_o (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      no_pend_o <= 1'b1;
      src_o     <= CODE_NONE;
      irq_o     <= 1'b0;
    end else begin
      no_pend_o <= !any_req;
      src_o     <= code_nxt;
      irq_o     <= any_req;
    end
  end
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk
  import uart_irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ls_req_i,
  input logic             rda_req_i,
  input logic             to_req_i,
  input logic             tx_set_i,
  input logic             ls_en_i,
  input logic             rx_en_i,
  input logic             tx_en_i,
  input logic             id_rd_i,
  input logic             thr_wr_i,
  input logic             no_pend_o,
  input logic [SRC_W-1:0] src_o,
  input logic             irq_o
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (rst)
    no_pend_o |-> (src_o == CODE_NONE) && !irq_o);

  assert_pend_irq_R10: assert property (@(posedge clk) disable iff (rst)
    !no_pend_o |-> irq_o);

  assert_ls_top_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ls_req_i && ls_en_i)) |-> (src_o == CODE_LS) && irq_o);

  assert_rda_over_to_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rda_req_i && to_req_i && rx_en_i && !(ls_req_i && ls_en_i)))
      |-> (src_o == CODE_RDA));

  assert_ls_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!ls_en_i)) |-> (src_o != CODE_LS));

  assert_thr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(thr_wr_i && !tx_set_i, 2)) |-> (src_o != CODE_TX));
endmodule

bind uart_irq_id uart_irq_id_chk chk (.*);

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
  logic clk = 1'b0;
  logic rst;
  logic ls_req_i, rda_req_i, to_req_i, tx_set_i;
  logic ls_en_i, rx_en_i, tx_en_i, id_rd_i, thr_wr_i;
  logic no_pend_o, irq_o;
  logic [2:0] src_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uart_irq_id dut (.*);

  // {ls, rda, to, ls_en, rx_en, tx_en, exp_src[2:0], exp_irq}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0_1_1_1_000_0,  // R10 idle
    10'b1_0_0_1_0_0_011_1,  // R2
    10'b1_0_0_0_1_1_000_0,  // R9 ls masked
    10'b0_1_0_0_1_0_010_1,  // R3
    10'b0_0_1_0_1_0_110_1,  // R4
    10'b0_1_1_1_1_1_010_1,  // R5
    10'b1_1_1_1_1_1_011_1,  // R2 over all
    10'b1_0_1_0_1_0_110_1,  // R9 masked ls, timeout shown
    10'b0_1_1_1_0_1_000_0,  // R9 rx masked
    10'b1_1_0_1_1_0_011_1   // R3 below ls
  };

  function automatic string vreq(input int i);
    case (i)
      0: vreq = "R10";
      1: vreq = "R2";
      2: vreq = "R9";
      3: vreq = "R3";
      4: vreq = "R4";
      5: vreq = "R5";
      6: vreq = "R2";
      7: vreq = "R9";
      8: vreq = "R9";
      default: vreq = "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] es, input logic ei);
    checks++;
    if (src_o !== es || irq_o !== ei || no_pend_o !== !ei) begin
      fails++;
      $display("FAIL %s: src=%b irq=%b no_pend=%b expected src=%b irq=%b no_pend=%b",
               req, src_o, irq_o, no_pend_o, es, ei, !ei);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tx;
    tx_set_i = 1'b1; cyc(1); tx_set_i = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1;
    {ls_req_i, rda_req_i, to_req_i, tx_set_i} = '0;
    {ls_en_i, rx_en_i, tx_en_i, id_rd_i, thr_wr_i} = '0;
    cyc(3);
    check("R1", 3'b000, 1'b0);
    rst = 1'b0;
    cyc(1);

    for (int v = 0; v < NV; v++) begin
      {ls_req_i, rda_req_i, to_req_i, ls_en_i, rx_en_i, tx_en_i} = VEC[v][9:4];
      cyc(1);
      check(vreq(v), VEC[v][3:1], VEC[v][0]);
    end
    {ls_req_i, rda_req_i, to_req_i} = '0;
    {ls_en_i, rx_en_i, tx_en_i} = 3'b111;
    cyc(1);

    // R11: change seen only after the next edge
    ls_req_i = 1'b1;
    #1 check("R11", 3'b000, 1'b0);
    cyc(1);
    check("R11", 3'b011, 1'b1);
    ls_req_i = 1'b0;
    cyc(1);

    // R6: latched transmitter-empty
    pulse_tx(); cyc(1);
    check("R6", 3'b001, 1'b1);
    cyc(2);
    check("R6", 3'b001, 1'b1);
    // R4: timeout outranks tx
    to_req_i = 1'b1; cyc(1);
    check("R4", 3'b110, 1'b1);
    to_req_i = 1'b0; cyc(1);
    check("R6", 3'b001, 1'b1);

    // R7: holding-register write clears
    thr_wr_i = 1'b1; cyc(1); thr_wr_i = 1'b0; cyc(1);
    check("R7", 3'b000, 1'b0);

    // R8: read that returned 02h clears
    pulse_tx(); cyc(1);
    id_rd_i = 1'b1; cyc(1); id_rd_i = 1'b0; cyc(1);
    check("R8", 3'b000, 1'b0);

    // R8: read that returned 06h leaves tx latched
    pulse_tx();
    ls_req_i = 1'b1; cyc(1);
    check("R8", 3'b011, 1'b1);
    id_rd_i = 1'b1; cyc(1); id_rd_i = 1'b0;
    ls_req_i = 1'b0; cyc(1);
    check("R8", 3'b001, 1'b1);
    thr_wr_i = 1'b1; cyc(1); thr_wr_i = 1'b0; cyc(1);

    // R9: latched while disabled, read while masked does not clear
    tx_en_i = 1'b0;
    pulse_tx(); cyc(1);
    check("R9", 3'b000, 1'b0);
    id_rd_i = 1'b1; cyc(1); id_rd_i = 1'b0;
    tx_en_i = 1'b1; cyc(1);
    check("R9", 3'b001, 1'b1);

    // R12: set coincident with clear keeps the request
    thr_wr_i = 1'b1; tx_set_i = 1'b1; cyc(1);
    thr_wr_i = 1'b0; tx_set_i = 1'b0; cyc(1);
    check("R12", 3'b001, 1'b1);
    id_rd_i = 1'b1; tx_set_i = 1'b1; cyc(1);
    id_rd_i = 1'b0; tx_set_i = 1'b0; cyc(1);
    check("R12", 3'b001, 1'b1);

    // R1: reset clears the latched request
    rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
    check("R1", 3'b000, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule